// File: doc/BRIEF.md
# True Random Source Controller with Startup Health Check

This block sits between a free-running noise bit stream and software. Software reaches it through a small 32-bit register read/write bus. It holds three controls: generator enable, raw-word output select, and a software reset. When the software reset is released while the generator is enabled, the block screens the first window of noise samples with two tests. A repetition-count test catches a stuck source. An adaptive-proportion test catches a biased source.

Only after that screening finishes clean does the block report itself ready. It then packs later noise bits into 32-bit words and flags each fresh word. Completion of the screening raises an interrupt. That interrupt has a per-event enable and a global mask. The post-processing path is not present, so the raw path is the only data path.

Top module: `trng_ctrl`

## Requirements
- R1: After `rst` the registers read as follows. Control (0x804) reads 0. Software reset (0x808) reads 1. Interrupt enable (0x818) reads 0x0001_0000, with only the mask bit set. Status (0x824) and ready (0x800) read 0. `irq` is low.
- R2: Control at 0x804 keeps enable at bit 31 and raw select at bit 16. Interrupt enable at 0x818 keeps event enables at bits 2:0 and the global mask at bit 16. All other bits of both registers read 0.
- R3: Noise samples are taken into the health check only while 0x808 bit 0 is 0 and the enable bit is 1. Samples offered at any other time leave the status register unchanged.
- R4: After 1024 accepted samples, status bit 18 (done) is set. After 1023 accepted samples it is still clear. Ready bit 0 of 0x800 is set when done is set and no failure bit is set.
- R5: Status bit 16 is set on the sample that completes a run of 32 identical consecutive bits in the window. A run of 31 leaves it clear.
- R6: Status bit 17 is set at the end of the window if either bit value occurred more than 800 times. Exactly 800 ones does not set it.
- R7: Once the check has passed and raw select is set, every 32 further samples form one word. The first sample of the word lands in bit 31. The word is readable at 0x828, and status bit 7 flags it. Bit 7 never sets after a failed check.
- R8: A read of 0x828 clears status bit 7. The bit stays clear until 32 further samples have been taken.
- R9: Ready register bits 15:8 count completed words. The count holds at 0x80.
- R10: `irq` is high while a done event is pending, event enable bit 0 is set and mask bit 16 is clear. The pending event remains until software reset.
- R11: Writing 1 to 0x808 bit 0 clears done, both failure flags, the valid flag, the word count and the pending interrupt.
- R12: With raw select clear, no words are formed. Status bit 7 and the count stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| noise_stb | input | 1 | One noise sample is offered this cycle |
| noise_bit | input | 1 | Noise sample value |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume a few things about the inputs. `bus_rd` and `bus_wr` are never high in the same cycle. `noise_stb` is a single-cycle strobe. Software reset is cleared only after the enables have been written.

The bench keeps within these assumptions. Every bus access and every noise sample comes from its own task, and each task drives one strobe for exactly one cycle.

The noise patterns are built to isolate the two tests. An opening run of 32 ones followed by alternation trips only the repetition test. A 7-of-8 ones pattern trips only the proportion test. A pattern with 25 ones in every 32 samples lands exactly on the proportion limit.

// File: rtl/trng_pkg.sv
package trng_pkg;
  // Register byte offsets (software-visible map)
  parameter logic [11:0] OFS_READY = 12'h800;
  parameter logic [11:0] OFS_CTRL  = 12'h804;
  parameter logic [11:0] OFS_SRST  = 12'h808;
  parameter logic [11:0] OFS_IEN   = 12'h818;
  parameter logic [11:0] OFS_STAT  = 12'h824;
  parameter logic [11:0] OFS_DATA  = 12'h828;

  // Bit positions
  parameter int B_EN      = 31;
  parameter int B_RAW     = 16;
  parameter int B_MASK    = 16;
  parameter int B_RC_FAIL = 16;
  parameter int B_AP_FAIL = 17;
  parameter int B_DONE    = 18;
  parameter int B_VALID   = 7;
endpackage

// File: rtl/trng_startup_check.sv
module trng_startup_check #(
  parameter int RC_LIMIT  = 32,
  parameter int AP_WINDOW = 1024,
  parameter int AP_LIMIT  = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  input  logic smp_stb,
  input  logic smp_bit,
  output logic done,
  output logic rc_fail,
  output logic ap_fail,
  output logic done_pulse
);
  localparam int SW = $clog2(AP_WINDOW + 1);
  localparam int RW = $clog2(RC_LIMIT + 1);

  logic [SW-1:0] cnt_q, ones_q, ones_nxt;
  logic [RW-1:0] run_q, run_nxt;
  logic          last_q, same, take;

  assign take     = active && !done && smp_stb;
  assign same     = (cnt_q != '0) && (smp_bit == last_q);
  assign ones_nxt = ones_q + SW'(smp_bit);
  assign run_nxt  = !same ? RW'(1) :
                    (run_q == RW'(RC_LIMIT)) ? run_q : run_q + RW'(1);

  always_ff @(posedge clk) begin
    done_pulse <= 1'b0;
    if (rst || clr) begin
      cnt_q   <= '0;
      ones_q  <= '0;
      run_q   <= '0;
      last_q  <= 1'b0;
      done    <= 1'b0;
      rc_fail <= 1'b0;
      ap_fail <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_q + SW'(1);
      ones_q <= ones_nxt;
      run_q  <= run_nxt;
      last_q <= smp_bit;
      if (run_nxt >= RW'(RC_LIMIT)) rc_fail <= 1'b1;
      if (cnt_q == SW'(AP_WINDOW - 1)) begin
        done       <= 1'b1;
        done_pulse <= 1'b1;
        if (ones_nxt > SW'(AP_LIMIT) || (SW'(AP_WINDOW) - ones_nxt) > SW'(AP_LIMIT))
          ap_fail <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trng_word_acc.sv
module trng_word_acc #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter int CNT_MAX = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              collect,
  input  logic              smp_stb,
  input  logic              smp_bit,
  input  logic              rd_take,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic [CNT_W-1:0]  xfer_cnt
);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-2:0] shift_q;
  logic [BW-1:0]     bits_q;
  logic              complete;

  assign complete = collect && smp_stb && (bits_q == BW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shift_q  <= '0;
      bits_q   <= '0;
      word     <= '0;
      valid    <= 1'b0;
      xfer_cnt <= '0;
    end else begin
      if (!collect) begin
        bits_q <= '0;
      end else if (smp_stb) begin
        shift_q <= {shift_q[WORD_W-3:0], smp_bit};
        bits_q  <= complete ? '0 : bits_q + BW'(1);
      end
      if (complete) begin
        word  <= {shift_q, smp_bit};
        valid <= 1'b1;
        if (xfer_cnt != CNT_W'(CNT_MAX)) xfer_cnt <= xfer_cnt + CNT_W'(1);
      end else if (rd_take) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
  import trng_pkg::*;
#(
  parameter int RC_LIMIT  = 32,
  parameter int AP_WINDOW = 1024,
  parameter int AP_LIMIT  = 800,
  parameter int CNT_MAX   = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        noise_stb,
  input  logic        noise_bit,
  output logic        irq
);
  localparam int CNT_W = 8;

  logic       en_q, raw_q, srst_q, mask_q, pend_q;
  logic [2:0] ien_q;
  logic       active, passed, collect, rd_take;
  logic       done, rc_fail, ap_fail, done_pulse;
  logic [31:0] word;
  logic        valid;
  logic [CNT_W-1:0] xfer_cnt;
  logic        unused_wbits;

  assign unused_wbits = ^{bus_wdata[30:17], bus_wdata[15:3]};
  assign active  = en_q && !srst_q;
  assign passed  = done && !rc_fail && !ap_fail;
  assign collect = passed && active && raw_q;
  assign rd_take = bus_rd && (bus_addr == OFS_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      raw_q  <= 1'b0;
      srst_q <= 1'b1;
      ien_q  <= '0;
      mask_q <= 1'b1;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL: begin
          en_q  <= bus_wdata[B_EN];
          raw_q <= bus_wdata[B_RAW];
        end
        OFS_SRST: srst_q <= bus_wdata[0];
        OFS_IEN: begin
          ien_q  <= bus_wdata[2:0];
          mask_q <= bus_wdata[B_MASK];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) pend_q <= 1'b0;
    else if (done_pulse) pend_q <= 1'b1;
    irq <= !rst && pend_q && ien_q[0] && !mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        OFS_READY: bus_rdata <= {16'b0, xfer_cnt, 7'b0, passed};
        OFS_CTRL: begin
          bus_rdata[B_EN]  <= en_q;
          bus_rdata[B_RAW] <= raw_q;
        end
        OFS_SRST: bus_rdata[0] <= srst_q;
        OFS_IEN: begin
          bus_rdata[2:0]    <= ien_q;
          bus_rdata[B_MASK] <= mask_q;
        end
        OFS_STAT: begin
          bus_rdata[B_RC_FAIL] <= rc_fail;
          bus_rdata[B_AP_FAIL] <= ap_fail;
          bus_rdata[B_DONE]    <= done;
          bus_rdata[B_VALID]   <= valid;
        end
        OFS_DATA: bus_rdata <= word;
        default: ;
      endcase
    end
  end

  trng_startup_check #(
    .RC_LIMIT(RC_LIMIT), .AP_WINDOW(AP_WINDOW), .AP_LIMIT(AP_LIMIT)
  ) u_check (
    .clk(clk), .rst(rst), .clr(srst_q), .active(active),
    .smp_stb(noise_stb), .smp_bit(noise_bit),
    .done(done), .rc_fail(rc_fail), .ap_fail(ap_fail), .done_pulse(done_pulse)
  );

  trng_word_acc #(
    .WORD_W(32), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
  ) u_acc (
    .clk(clk), .rst(rst), .clr(srst_q), .collect(collect),
    .smp_stb(noise_stb), .smp_bit(noise_bit), .rd_take(rd_take),
    .word(word), .valid(valid), .xfer_cnt(xfer_cnt)
  );
endmodule

// File: rtl/trng_ctrl_chk.sv
module trng_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       srst,
  input logic       en,
  input logic       mask,
  input logic       irq,
  input logic       done,
  input logic       rc_fail,
  input logic       ap_fail,
  input logic       valid,
  input logic [7:0] xfer_cnt
);
  a_r7_valid_after_pass: assert property (@(posedge clk) disable iff (rst)
    valid |-> (done && !rc_fail && !ap_fail));

  a_r9_cnt_sat: assert property (@(posedge clk) disable iff (rst)
    xfer_cnt <= 8'h80);

  a_r10_mask: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq);

  a_r11_swrst_clear: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!done && !valid && !rc_fail && !ap_fail && xfer_cnt == 8'h0));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !srst) |=> $stable(done) && $stable(rc_fail) && $stable(ap_fail));

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !srst) |=> done);
endmodule

bind trng_ctrl trng_ctrl_chk u_trng_ctrl_chk (
  .clk(clk), .rst(rst), .srst(srst_q), .en(en_q), .mask(mask_q), .irq(irq),
  .done(done), .rc_fail(rc_fail), .ap_fail(ap_fail), .valid(valid),
  .xfer_cnt(xfer_cnt)
);

// File: tb/tb_trng_ctrl.sv
`timescale 1ns/1ps
module tb_trng_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        noise_stb = 1'b0, noise_bit = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trng_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .noise_stb(noise_stb), .noise_bit(noise_bit), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic feed(input logic b);
    @(negedge clk); noise_stb = 1'b1; noise_bit = b;
    @(negedge clk); noise_stb = 1'b0;
  endtask

  task automatic feed_alt(input int n);
    for (int i = 0; i < n; i++) feed(i[0]);
  endtask

  task automatic feed_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) feed(w[i]);
  endtask

  task automatic restart(input logic [31:0] ctrl);
    wr(12'h808, 32'h1);
    wr(12'h818, 32'h0000_0001);
    wr(12'h804, ctrl);
    wr(12'h808, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h804, d); check("R1 ctrl", d, 32'h0);
    rd(12'h808, d); check("R1 srst", d, 32'h1);
    rd(12'h818, d); check("R1 ien", d, 32'h0001_0000);
    rd(12'h824, d); check("R1 status", d, 32'h0);
    rd(12'h800, d); check("R1 ready", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h804, 32'hFFFF_FFFF); rd(12'h804, d); check("R2 ctrl bits", d, 32'h8001_0000);
    wr(12'h818, 32'hFFFF_FFFF); rd(12'h818, d); check("R2 ien bits", d, 32'h0001_0007);
    wr(12'h804, 32'h0); wr(12'h818, 32'h0001_0000);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(12'h804, 32'h8001_0000);   // enabled but still in software reset
    feed_alt(1030);
    rd(12'h824, d); check("R3 held in srst", d, 32'h0);
    wr(12'h804, 32'h0);
    wr(12'h808, 32'h0);           // out of reset, disabled
    feed_alt(1030);
    rd(12'h824, d); check("R3 disabled", d, 32'h0);
  endtask

  task automatic t_pass();
    logic [31:0] d;
    restart(32'h8001_0000);
    feed_alt(1023);
    rd(12'h824, d); check("R4 not done at 1023", d, 32'h0);
    feed(1'b1);
    rd(12'h824, d); check("R4 done", d, 32'h0004_0000);
    rd(12'h800, d); check("R4 ready", d, 32'h0000_0001);
    repeat (4) @(negedge clk);
    check("R10 irq", {31'b0, irq}, 32'h1);
    wr(12'h818, 32'h0001_0001); repeat (2) @(negedge clk);
    check("R10 masked", {31'b0, irq}, 32'h0);
    wr(12'h818, 32'h0000_0000); repeat (2) @(negedge clk);
    check("R10 event disabled", {31'b0, irq}, 32'h0);
    wr(12'h818, 32'h0000_0001); repeat (2) @(negedge clk);
    check("R10 unmasked again", {31'b0, irq}, 32'h1);
    feed_word(32'hA5C3_1E0F);
    rd(12'h824, d); check("R7 valid", d, 32'h0004_0080);
    rd(12'h828, d); check("R7 word", d, 32'hA5C3_1E0F);
    rd(12'h824, d); check("R8 cleared by read", d, 32'h0004_0000);
    for (int i = 30; i >= 0; i--) feed(i[0]);
    rd(12'h824, d); check("R8 after 31 bits", d, 32'h0004_0000);
    feed(1'b1);
    rd(12'h824, d); check("R8 after 32 bits", d, 32'h0004_0080);
    rd(12'h828, d); check("R7 second word", d, 32'h5555_5555);
    rd(12'h800, d); check("R9 count 2", d, 32'h0000_0201);
    for (int k = 0; k < 126; k++) feed_word(32'h1234_0000 + k);
    rd(12'h800, d); check("R9 count 0x80", d, 32'h0000_8001);
    feed_word(32'hDEAD_BEEF);
    rd(12'h800, d); check("R9 saturated", d, 32'h0000_8001);
    rd(12'h828, d); check("R7 word after saturation", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    wr(12'h808, 32'h1);
    repeat (2) @(negedge clk);
    rd(12'h824, d); check("R11 status cleared", d, 32'h0);
    rd(12'h800, d); check("R11 ready cleared", d, 32'h0);
    check("R11 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rc();
    logic [31:0] d;
    restart(32'h8001_0000);
    for (int i = 0; i < 31; i++) feed(1'b1);
    rd(12'h824, d); check("R5 run of 31", d, 32'h0);
    feed(1'b1);
    rd(12'h824, d); check("R5 run of 32", d, 32'h0001_0000);
    feed_alt(992);
    rd(12'h824, d); check("R5 done with rc only", d, 32'h0005_0000);
    feed_alt(64);
    rd(12'h824, d); check("R7 no data after fail", d, 32'h0005_0000);
    rd(12'h800, d); check("R7 not ready after fail", d, 32'h0);
  endtask

  task automatic t_ap();
    logic [31:0] d;
    restart(32'h8001_0000);
    for (int i = 0; i < 1024; i++) feed((i % 8) != 7);
    rd(12'h824, d); check("R6 bias 896", d, 32'h0006_0000);
    restart(32'h8001_0000);
    for (int i = 0; i < 1024; i++) feed((i % 32) < 25);
    rd(12'h824, d); check("R6 exactly 800 passes", d, 32'h0004_0000);
  endtask

  task automatic t_rawoff();
    logic [31:0] d;
    restart(32'h8000_0000);
    feed_alt(1024);
    feed_alt(64);
    rd(12'h824, d); check("R12 no valid", d, 32'h0004_0000);
    rd(12'h800, d); check("R12 no count", d, 32'h0000_0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_gate();
    t_pass();
    t_swrst();
    t_rc();
    t_ap();
    t_rawoff();
    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule